// File: doc/BRIEF.md
# Glitch-Free Reference Clock Switchover

This block picks one of two reference clocks and drives a single output clock from it. A switch is requested by a rising edge on a request input. The block first gates the output off on a falling edge of the clock now in use. It then connects the other clock on one of that clock's own falling edges. Because both changes happen while the affected clock is low, the output never carries a runt high or low phase. A status output reports which input drives the output. The status changes in the same instant as the multiplexer.

A free-running supervisory clock runs the control side. This clock must run at more than twice the faster reference. It synchronizes the request and checks that the request is held long enough. It also watches both reference clocks for missing edges. A clock that has stopped raises its own bad flag. If the selected clock goes bad while the request is low and the other clock is healthy, the block fails over to the other clock by itself. While the request is held high, no automatic or further switching takes place. A switch towards a clock that is not running leaves the output gated low until that clock starts again.

Top module: `refclk_switchover`

## Requirements
- R1: While `rstN` is low and right after it rises, input A is selected: `activeSel` is 0 and both bad flags are 0. Reset also acts at once when it is asserted in the middle of operation.
- R2: A switch is accepted only after a low-to-high change of `switchReq` that stays high for at least `HoldCycles` consecutive samples of `monClk` after synchronization (default 3). A pulse lasting two `monClk` cycles causes no switch.
- R3: A high-to-low change of `switchReq` never causes a switch.
- R4: In steady state `clkOut` repeats the selected input exactly. Every high and low phase of `clkOut` lasts at least the shorter input half-period, including phases around a switch. The two gate enables are never both on.
- R5: `activeSel` is 0 when input A drives `clkOut` and 1 when input B drives it. It changes only when the multiplexer connects the new clock.
- R6: When a switch targets a clock that is not running, `clkOut` stays low and `activeSel` keeps its old value. The switch completes once that clock runs again.
- R7: While the synchronized request is high, no automatic failover and no further switch takes place, even if the selected clock is bad.
- R8: A bad flag (`clkBadA`, `clkBadB`) rises after its input shows no level change for `BadLimit` cycles of `monClk` (default 16). It clears on the next edge of that input. During a manual switch with both clocks running, neither flag rises.
- R9: When the request is low, the selected clock is flagged bad and the other clock is not, the block switches to the other clock without a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| monClk | input | 1 | Supervisory clock for request handling and clock watching |
| rstN | input | 1 | Asynchronous active-low reset |
| clkA | input | 1 | Reference clock input A (selected after reset) |
| clkB | input | 1 | Reference clock input B |
| switchReq | input | 1 | Manual switch request, acted on at its rising edge |
| clkOut | output | 1 | Glitch-free multiplexed clock |
| activeSel | output | 1 | 0 when A drives `clkOut`, 1 when B drives it |
| clkBadA | output | 1 | Input A has stopped toggling |
| clkBadB | output | 1 | Input B has stopped toggling |

## Verification
A manual switch passes through several stages before `activeSel` and `clkOut` settle. The request takes two `monClk` samples to synchronize. It then needs `HoldCycles` samples to be accepted and one more register to change the target. Each gate enable then waits two rising edges and one falling edge of its own clock. With the bench clocks the whole switch takes about 25 `monClk` cycles. A bad flag follows a stopped clock after `BadLimit` plus three `monClk` cycles. The bench applies each stimulus at a falling edge of `monClk` and waits 50 cycles before it samples. It then compares rising-edge counts of `clkOut` and the expected source over a 40-cycle window. The reference clocks are phased so that none of their edges lands on a `monClk` edge, and a continuous monitor times every `clkOut` phase whenever switching with running clocks is under test.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  // strobes from the control side into the clock datapath
  typedef struct packed {
    logic       selB;  // target input: 0 = A, 1 = B
    logic [1:0] kill;  // asynchronous clear of a dead lane's gate
  } swStrobe_t;

endpackage

// File: rtl/clksw_edge_watch.sv
module clksw_edge_watch #(
  parameter int BadLimit   = 16,
  parameter int SyncStages = 2
) (
  input  logic monClk,
  input  logic rstN,
  input  logic clkIn,
  output logic bad
);
  localparam int CntW = $clog2(BadLimit + 1);

  logic [SyncStages:0] smp;
  logic [CntW-1:0]     quietCnt;
  logic                edgeSeen;

  always_ff @(posedge monClk or negedge rstN) begin
    if (!rstN) smp <= '0;
    else       smp <= {smp[SyncStages-1:0], clkIn};
  end

  assign edgeSeen = smp[SyncStages] ^ smp[SyncStages-1];

  always_ff @(posedge monClk or negedge rstN) begin
    if (!rstN) begin
      quietCnt <= '0;
      bad      <= 1'b0;
    end else if (edgeSeen) begin
      quietCnt <= '0;
      bad      <= 1'b0;
    end else if (quietCnt == CntW'(BadLimit)) begin
      bad      <= 1'b1;
    end else begin
      quietCnt <= quietCnt + 1'b1;
    end
  end
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl import clksw_pkg::*; #(
  parameter int HoldCycles = 3,
  parameter int BadLimit   = 16,
  parameter int SyncStages = 2
) (
  input  logic       monClk,
  input  logic       rstN,
  input  logic       switchReq,
  input  logic [1:0] clkIn,
  output logic [1:0] clkBad,
  output swStrobe_t  strobes
);
  localparam int HoldW = $clog2(HoldCycles + 1);

  logic [SyncStages-1:0] reqPipe;
  logic                  reqS;
  logic                  reqPrev;
  logic                  reqRise;
  logic                  armed;
  logic [HoldW-1:0]      holdCnt;
  logic                  fire;
  logic                  autoGo;
  logic                  selB;
  logic [1:0]            killQ;

  // one missing-edge watcher per reference input
  for (genvar i = 0; i < 2; i++) begin : g_watch
    clksw_edge_watch #(
      .BadLimit  (BadLimit),
      .SyncStages(SyncStages)
    ) u_watch (
      .monClk(monClk),
      .rstN  (rstN),
      .clkIn (clkIn[i]),
      .bad   (clkBad[i])
    );
  end

  always_ff @(posedge monClk or negedge rstN) begin
    if (!rstN) begin
      reqPipe <= '0;
      reqPrev <= 1'b0;
    end else begin
      reqPipe <= {reqPipe[SyncStages-2:0], switchReq};
      reqPrev <= reqS;
    end
  end

  assign reqS    = reqPipe[SyncStages-1];
  assign reqRise = reqS & ~reqPrev;
  assign fire    = armed & reqS & (holdCnt == HoldW'(HoldCycles - 1));
  assign autoGo  = ~reqS & ~armed &
                   (selB ? (clkBad[1] & ~clkBad[0]) : (clkBad[0] & ~clkBad[1]));

  // request qualification: count samples held high since the rising edge
  always_ff @(posedge monClk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      holdCnt <= '0;
    end else if (reqRise) begin
      armed   <= 1'b1;
      holdCnt <= HoldW'(1);
    end else if (!reqS || fire) begin
      armed   <= 1'b0;
    end else if (armed) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  always_ff @(posedge monClk or negedge rstN) begin
    if (!rstN) begin
      selB  <= 1'b0;
      killQ <= '0;
    end else begin
      if (fire || autoGo) selB <= ~selB;
      killQ[0] <= clkBad[0] & selB;
      killQ[1] <= clkBad[1] & ~selB;
    end
  end

  assign strobes.selB = selB;
  assign strobes.kill = killQ;
endmodule

// File: rtl/clksw_gate_chain.sv
module clksw_gate_chain #(
  parameter int SyncStages = 2,
  parameter bit InitOn     = 1'b0
) (
  input  logic clkIn,
  input  logic rstN,
  input  logic kill,
  input  logic want,
  output logic en
);
  logic [SyncStages-1:0] syncQ;

  // bring the enable request into this clock's domain
  always_ff @(posedge clkIn or negedge rstN or posedge kill) begin
    if (!rstN)     syncQ <= {SyncStages{InitOn}};
    else if (kill) syncQ <= '0;
    else           syncQ <= {syncQ[SyncStages-2:0], want};
  end

  // the gate itself only moves while its clock is low
  always_ff @(negedge clkIn or negedge rstN or posedge kill) begin
    if (!rstN)     en <= InitOn;
    else if (kill) en <= 1'b0;
    else           en <= syncQ[SyncStages-1];
  end
endmodule

// File: rtl/clksw_datapath.sv
module clksw_datapath import clksw_pkg::*; #(
  parameter int SyncStages = 2
) (
  input  logic [1:0] clkIn,
  input  logic       rstN,
  input  swStrobe_t  strobes,
  output logic [1:0] gateEn,
  output logic       clkOut,
  output logic       activeSel
);
  logic [1:0] want;

  // each lane may open only once the other lane is seen closed
  assign want[0] = ~strobes.selB & ~gateEn[1];
  assign want[1] =  strobes.selB & ~gateEn[0];

  for (genvar i = 0; i < 2; i++) begin : g_lane
    clksw_gate_chain #(
      .SyncStages(SyncStages),
      .InitOn    (i == 0)
    ) u_lane (
      .clkIn(clkIn[i]),
      .rstN (rstN),
      .kill (strobes.kill[i]),
      .want (want[i]),
      .en   (gateEn[i])
    );
  end

  assign clkOut    = |(clkIn & gateEn);
  // while both gates are closed the old source is still reported
  assign activeSel = gateEn[1] | (~gateEn[0] & ~strobes.selB);
endmodule

// File: rtl/refclk_switchover.sv
module refclk_switchover import clksw_pkg::*; #(
  parameter int HoldCycles = 3,
  parameter int BadLimit   = 16,
  parameter int SyncStages = 2
) (
  input  logic monClk,
  input  logic rstN,
  input  logic clkA,
  input  logic clkB,
  input  logic switchReq,
  output logic clkOut,
  output logic activeSel,
  output logic clkBadA,
  output logic clkBadB
);
  logic [1:0] clkIn;
  logic [1:0] clkBad;
  logic [1:0] gateEn;
  swStrobe_t  strobes;

  assign clkIn = {clkB, clkA};

  clksw_ctrl #(
    .HoldCycles(HoldCycles),
    .BadLimit  (BadLimit),
    .SyncStages(SyncStages)
  ) u_ctrl (
    .monClk   (monClk),
    .rstN     (rstN),
    .switchReq(switchReq),
    .clkIn    (clkIn),
    .clkBad   (clkBad),
    .strobes  (strobes)
  );

  clksw_datapath #(
    .SyncStages(SyncStages)
  ) u_dp (
    .clkIn    (clkIn),
    .rstN     (rstN),
    .strobes  (strobes),
    .gateEn   (gateEn),
    .clkOut   (clkOut),
    .activeSel(activeSel)
  );

  assign clkBadA = clkBad[0];
  assign clkBadB = clkBad[1];
endmodule

// File: rtl/clksw_chk.sv
module clksw_chk (
  input logic       monClk,
  input logic       rstN,
  input logic [1:0] gateEn,
  input logic       activeSel,
  input logic [1:0] clkBad,
  input logic       reqS,
  input logic       armed,
  input logic       selB
);
  // R1
  reset_sel_chk: assert property (@(posedge monClk) disable iff (!rstN)
    $rose(rstN) |-> (!activeSel && clkBad == 2'b00));

  // R4
  gate_exclusive_chk: assert property (@(posedge monClk) disable iff (!rstN)
    !(gateEn[0] && gateEn[1]));

  // R7
  manual_override_chk: assert property (@(posedge monClk) disable iff (!rstN)
    ($past(reqS) && !$past(armed)) |-> $stable(selB));

  // R3
  fall_no_switch_chk: assert property (@(posedge monClk) disable iff (!rstN)
    ($fell(reqS) && clkBad == 2'b00) |=> $stable(selB));

  // R9
  auto_failover_chk: assert property (@(posedge monClk) disable iff (!rstN)
    (!reqS && !armed && !selB && clkBad[0] && !clkBad[1]) |=> selB);
endmodule

bind refclk_switchover clksw_chk u_chk (
  .monClk   (monClk),
  .rstN     (rstN),
  .gateEn   (gateEn),
  .activeSel(activeSel),
  .clkBad   (clkBad),
  .reqS     (u_ctrl.reqS),
  .armed    (u_ctrl.armed),
  .selB     (strobes.selB)
);

// File: tb/test_refclk_switchover.sv
`timescale 1ns/1ps
module test_refclk_switchover;
  logic monClk = 1'b0;
  logic rstN = 1'b0;
  logic clkA = 1'b0;
  logic clkB = 1'b0;
  logic switchReq = 1'b0;
  logic runA = 1'b1;
  logic runB = 1'b1;
  logic clkOut, activeSel, clkBadA, clkBadB;

  int nChecks = 0;
  int nErr = 0;

  refclk_switchover i_refclk_switchover (
    .monClk(monClk), .rstN(rstN), .clkA(clkA), .clkB(clkB),
    .switchReq(switchReq), .clkOut(clkOut), .activeSel(activeSel),
    .clkBadA(clkBadA), .clkBadB(clkBadB)
  );

  // 125 MHz supervisory clock; reference edges all fall on odd ns
  always #4 monClk = ~monClk;
  initial begin #1; forever begin #10; if (runA || clkA) clkA = ~clkA; end end
  initial begin #3; forever begin #14; if (runB || clkB) clkB = ~clkB; end end

  // edge counting window
  logic winOn = 1'b0;
  int nOut = 0, nA = 0, nB = 0;
  always @(posedge clkOut) if (winOn) nOut++;
  always @(posedge clkA)   if (winOn) nA++;
  always @(posedge clkB)   if (winOn) nB++;

  // phase-width monitor, shortest input half-period is 10 ns
  logic pulseOn = 1'b0;
  logic haveT = 1'b0;
  realtime lastT = 0.0;
  int pulseErr = 0;
  always @(clkOut) begin
    if (pulseOn && haveT && ($realtime - lastT) < 9.99) pulseErr++;
    lastT = $realtime;
    haveT = pulseOn;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int k = 0; k < n; k++) @(negedge monClk);
  endtask

  task automatic measure(output int o, output int a, output int b);
    nOut = 0; nA = 0; nB = 0;
    winOn = 1'b1;
    waitCyc(40);
    winOn = 1'b0;
    o = nOut; a = nA; b = nB;
  endtask

  task automatic setPulse(input logic on);
    if (on && !pulseOn) haveT = 1'b0;
    pulseOn = on;
  endtask

  typedef struct packed {
    logic       req;
    logic       runA;
    logic       runB;
    logic       pulse;
    logic       expSel;
    logic       expBadA;
    logic       expBadB;
    logic [1:0] expSrc;   // 0 = A, 1 = B, 2 = no clock
  } vec_t;

  localparam int NumVecs = 11;
  localparam vec_t Vecs [NumVecs] = '{
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},  // R4 R5 steady on A
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1},  // R2 R5 R8 manual to B
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1},  // R3 falling edge ignored
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},  // R2 R4 manual back to A
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2},  // R7 R8 A dies, request held
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1},  // R9 failover to B
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1},  // R8 flag clears
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0},  // R9 B dies, back to A
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2},  // R6 R7 switch to dead B waits
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1},  // R6 B resumes, switch completes
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1}   // R3 R4 release request
  };

  initial begin
    int o, a, b, expCnt;
    // R1 reset state
    waitCyc(3);
    chk("R1 activeSel in reset", int'(activeSel), 0);
    chk("R1 clkBadA in reset", int'(clkBadA), 0);
    chk("R1 clkBadB in reset", int'(clkBadB), 0);
    rstN = 1'b1;
    waitCyc(2);
    chk("R1 activeSel after reset", int'(activeSel), 0);

    for (int v = 0; v < NumVecs; v++) begin
      setPulse(Vecs[v].pulse);
      switchReq = Vecs[v].req;
      runA = Vecs[v].runA;
      runB = Vecs[v].runB;
      waitCyc(50);
      measure(o, a, b);
      expCnt = (Vecs[v].expSrc == 2'd0) ? a : (Vecs[v].expSrc == 2'd1) ? b : 0;
      chk($sformatf("R5 vector %0d activeSel", v), int'(activeSel), int'(Vecs[v].expSel));
      chk($sformatf("R8 vector %0d clkBadA", v), int'(clkBadA), int'(Vecs[v].expBadA));
      chk($sformatf("R8 vector %0d clkBadB", v), int'(clkBadB), int'(Vecs[v].expBadB));
      chk($sformatf("R4 vector %0d clkOut rising edges", v), o, expCnt);
    end

    // R2 boundary: a two-cycle request pulse is too short
    switchReq = 1'b1;
    waitCyc(2);
    switchReq = 1'b0;
    waitCyc(50);
    measure(o, a, b);
    chk("R2 short pulse keeps activeSel", int'(activeSel), 1);
    chk("R2 short pulse keeps source B", o, b);

    // R1 reset in mid-operation while B is selected
    setPulse(1'b0);
    rstN = 1'b0;
    #2;
    chk("R1 async reset activeSel", int'(activeSel), 0);
    chk("R1 async reset clkBadB", int'(clkBadB), 0);
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(50);
    measure(o, a, b);
    chk("R1 output follows A after reset", o, a);
    chk("R1 activeSel after second reset", int'(activeSel), 0);

    // R4 phase widths gathered during switches with both clocks running
    chk("R4 short clkOut phases", pulseErr, 0);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    #(20000 * 8);
    nChecks++;
    nErr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule